// File: doc/BRIEF.md
# Programmable slow-bus strobe sequencer

The block runs a single access to a slow external device, such as a boot ROM or a slow peripheral port, that sits on a shared memory bus. When the block is idle and `start_i` is high, it takes a copy of the address, the chip selects, the write data, the direction and the timing word. It then loads a down-counter with a cycle count. Which count it loads depends on the addressed region: boot-ROM accesses use one count and slow-port accesses use another. The counter steps down once per clock until it reaches zero. The access therefore lasts the cycle count plus one clocks.

Each edge of the active-low enable and of the active-low read or write strobe is its own match point on the counter. A requester changes the shape of the access by programming four 8-bit compare fields. No fixed wait-state table is involved. For a read, the block captures the data bus on the clock edge where the read strobe releases. For a write, it drives the write data for the whole access. The block pulses done in the last counted clock.

Top module: `slow_strobe_seq`

## Requirements
- R1: After reset, and whenever idle, busy_o and done_o are 0. en_no, rd_no and we_no are 1. cs_no is all ones and dq_oe_o is 0. After reset, rdata_o is 0.
- R2: A start is accepted in an idle cycle. The counter is loaded with N, taken from cnt_cfg_i[7:0] when region_i=0 (boot ROM) and from cnt_cfg_i[15:8] when region_i=1 (slow port). It takes N, N-1, …, 0 on consecutive clocks, so busy_o is high for N+1 clocks. done_o is high only in the clock where the counter is 0, and busy_o is low in the clock after that.
- R3: The timing word is taken at start. Its field [7:0] is the enable assert value A and field [15:8] is the enable release value D. en_no is 0 exactly in the clocks whose count k satisfies D < k <= A.
- R4: Field [23:16] is the strobe assert value and field [31:24] is the strobe release value. Under the same rule as R3, the strobe is low in the matching counts. The strobe appears on rd_no when write_i=0 at start and on we_no when write_i=1 at start. The other of the two stays 1.
- R5: A strobe whose assert value is not greater than its release value, or is greater than N, is never asserted. The access still runs N+1 clocks and still ends with done.
- R6: For the whole access, addr_o holds the captured address and cs_no holds the bitwise inverse of the captured cs_i.
- R7: On a read with a valid strobe, rdata_o takes the value of rdata_bus_i from the clock whose count is the strobe release value plus one. The new value is visible from the next clock on. On a write, or when the strobe is invalid, rdata_o keeps its previous value.
- R8: During a write access, dq_oe_o is 1 and wdata_o holds the captured write data for every clock of the access. dq_oe_o is 0 during read accesses.
- R9: While busy_o is high, start_i has no effect. The access length, addr_o and cs_no are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access request, accepted only when idle |
| region_i | input | 1 | 0 = boot ROM count, 1 = slow-port count |
| write_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | AW | Access address |
| cs_i | input | CSW | Chip selects to activate (active high) |
| wdata_i | input | DW | Write data |
| timing_cfg_i | input | 32 | Compare fields: [7:0] enable assert, [15:8] enable release, [23:16] strobe assert, [31:24] strobe release |
| cnt_cfg_i | input | 32 | [7:0] boot-ROM cycle count, [15:8] slow-port cycle count |
| rdata_bus_i | input | DW | Data bus from the device |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | High in the last clock of an access |
| en_no | output | 1 | Device enable, active low |
| cs_no | output | CSW | Chip selects, active low |
| rd_no | output | 1 | Read strobe, active low |
| we_no | output | 1 | Write strobe, active low |
| addr_o | output | AW | Address held for the access |
| wdata_o | output | DW | Write data held for the access |
| dq_oe_o | output | 1 | Data bus drive enable for writes |
| rdata_o | output | DW | Captured read data |

## Verification
The hardest case is the read capture. The bench must show that the sampled word came from the single clock just before the strobe releases, and not from a neighbouring clock. To make that visible, the bench changes the data bus on every counted clock to a pattern mixed with the current count, so only one clock's word can match. Invalid compare settings do not come up naturally. The random draws place the compare fields up to two counts beyond the cycle count, and the directed cases set equal assert and release values. Both make a strobe that stays quiet while done still arrives. A start issued in the middle of every random access shows whether it disturbs the address or the length.

// File: rtl/slow_seq_pkg.sv
package slow_seq_pkg;
  localparam int CNT_W = 8;

  // packed MSB first: matches timing word bit positions
  typedef struct packed {
    logic [CNT_W-1:0] st_release;
    logic [CNT_W-1:0] st_assert;
    logic [CNT_W-1:0] en_release;
    logic [CNT_W-1:0] en_assert;
  } timing_t;
endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o,
  output logic          done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      busy_o <= 1'b0;
    end else if (load_i && !busy_o) begin
      cnt_o  <= load_val_i;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt_o == '0) busy_o <= 1'b0;
      else             cnt_o  <= cnt_o - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt_o == '0);

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt_o != '0 |=> busy_o && cnt_o == CW'($past(cnt_o) - 1'b1));
  a_r2_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/strobe_match.sv
module strobe_match #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] max_i,
  input  logic [CW-1:0] assert_i,
  input  logic [CW-1:0] release_i,
  output logic          active_o,
  output logic          last_o
);
  logic valid;
  assign valid    = (assert_i > release_i) && (assert_i <= max_i);
  assign active_o = busy_i && valid && (cnt_i <= assert_i) && (cnt_i > release_i);
  assign last_o   = busy_i && valid && (cnt_i == CW'(release_i + 1'b1));

  a_r3_rise_at_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> cnt_i == assert_i);
  a_r3_fall_at_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> busy_i && cnt_i == release_i);
endmodule

// File: rtl/slow_strobe_seq.sv
module slow_strobe_seq
  import slow_seq_pkg::*;
#(
  parameter int AW  = 19,
  parameter int CSW = 4,
  parameter int DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           region_i,
  input  logic           write_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [CSW-1:0] cs_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [31:0]    timing_cfg_i,
  input  logic [31:0]    cnt_cfg_i,
  input  logic [DW-1:0]  rdata_bus_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           en_no,
  output logic [CSW-1:0] cs_no,
  output logic           rd_no,
  output logic           we_no,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  wdata_o,
  output logic           dq_oe_o,
  output logic [DW-1:0]  rdata_o
);
  localparam int CW = CNT_W;
  localparam int NS = 2; // 0: enable, 1: read/write strobe

  logic           accept;
  logic [CW-1:0]  load_cnt, cnt, max_q;
  logic [CSW-1:0] cs_q;
  logic           write_q;
  timing_t        timing_q;
  logic [CW-1:0]  s_assert [NS];
  logic [CW-1:0]  s_release[NS];
  logic [NS-1:0]  s_active, s_last;

  assign accept   = start_i && !busy_o;
  assign load_cnt = region_i ? cnt_cfg_i[2*CW-1:CW] : cnt_cfg_i[CW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      cs_q     <= '0;
      wdata_o  <= '0;
      write_q  <= 1'b0;
      timing_q <= '0;
      max_q    <= '0;
    end else if (accept) begin
      addr_o   <= addr_i;
      cs_q     <= cs_i;
      wdata_o  <= wdata_i;
      write_q  <= write_i;
      timing_q <= timing_t'(timing_cfg_i);
      max_q    <= load_cnt;
    end
  end

  seq_counter #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (load_cnt),
    .cnt_o      (cnt),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign s_assert[0]  = timing_q.en_assert;
  assign s_release[0] = timing_q.en_release;
  assign s_assert[1]  = timing_q.st_assert;
  assign s_release[1] = timing_q.st_release;

  for (genvar g = 0; g < NS; g++) begin : g_strobe
    strobe_match #(.CW(CW)) u_match (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .busy_i    (busy_o),
      .cnt_i     (cnt),
      .max_i     (max_q),
      .assert_i  (s_assert[g]),
      .release_i (s_release[g]),
      .active_o  (s_active[g]),
      .last_o    (s_last[g])
    );
  end

  assign en_no   = ~s_active[0];
  assign rd_no   = ~(s_active[1] && !write_q);
  assign we_no   = ~(s_active[1] && write_q);
  assign cs_no   = busy_o ? ~cs_q : '1;
  assign dq_oe_o = busy_o && write_q;

  // read capture on the edge where the strobe releases
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   rdata_o <= '0;
    else if (s_last[1] && !write_q) rdata_o <= rdata_bus_i;
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> en_no && rd_no && we_no && (&cs_no) && !dq_oe_o && !done_o);
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !we_no));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(addr_o) && $stable(cs_no));
  a_r9_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(addr_o) && $stable(wdata_o));
  a_r7_rdata_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(rdata_o));
endmodule

// File: tb/slow_strobe_seq_bench.sv
`timescale 1ns/1ps
module slow_strobe_seq_bench;
  localparam int AW = 19, CSW = 4, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, region = 0, write = 0;
  logic [AW-1:0] addr = '0;
  logic [CSW-1:0] cs = '0;
  logic [DW-1:0] wdata = '0, bus = '0;
  logic [31:0] tcfg = '0, ccfg = '0;
  logic busy, done, en_n, rd_n, we_n, oe;
  logic [CSW-1:0] cs_n;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] wdata_out, rdata;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] rdata_exp = '0;

  always #4 clk = ~clk;

  slow_strobe_seq #(.AW(AW), .CSW(CSW), .DW(DW)) u_slow_strobe_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .region_i(region),
    .write_i(write), .addr_i(addr), .cs_i(cs), .wdata_i(wdata),
    .timing_cfg_i(tcfg), .cnt_cfg_i(ccfg), .rdata_bus_i(bus),
    .busy_o(busy), .done_o(done), .en_no(en_n), .cs_no(cs_n),
    .rd_no(rd_n), .we_no(we_n), .addr_o(addr_out), .wdata_o(wdata_out),
    .dq_oe_o(oe), .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit on_at(input int k, input int a, input int d, input int n);
    return (a > d) && (a <= n) && (k <= a) && (k > d);
  endfunction

  task automatic check_idle(input string req);
    chk(!busy && !done, req, {busy, done}, 2'b00);
    chk(en_n && rd_n && we_n && !oe, req, {en_n, rd_n, we_n, oe}, 4'b1110);
    chk(cs_n == '1, req, cs_n, {CSW{1'b1}});
    chk(rdata == rdata_exp, req, rdata, rdata_exp);
  endtask

  // one complete access, checked clock by clock; starts and ends at a negedge
  task automatic run_access(input bit rg, input bit wr, input logic [AW-1:0] ad,
                            input logic [CSW-1:0] c, input logic [DW-1:0] wd,
                            input logic [31:0] tc, input logic [31:0] cc,
                            input logic [DW-1:0] pat, input bit poke);
    int n, ea, ed, sa, sd;
    bit s_on;
    n  = rg ? int'(cc[15:8]) : int'(cc[7:0]);
    ea = int'(tc[7:0]);   ed = int'(tc[15:8]);
    sa = int'(tc[23:16]); sd = int'(tc[31:24]);
    region = rg; write = wr; addr = ad; cs = c; wdata = wd; tcfg = tc; ccfg = cc;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    // scramble inputs: captured copy must be used
    addr = ~ad; wdata = ~wd; tcfg = ~tc; write = ~wr;
    for (int k = n; k >= 0; k--) begin
      @(negedge clk);
      bus = pat ^ DW'(k);
      if (poke && k == n / 2) start = 1'b1; else start = 1'b0;
      s_on = on_at(k, sa, sd, n);
      chk(busy, "R2 busy", busy, 1);
      chk(done == (k == 0), "R2 done", done, k == 0);
      chk(en_n == !on_at(k, ea, ed, n), "R3/R5 enable", en_n, !on_at(k, ea, ed, n));
      chk(rd_n == !(s_on && !wr), "R4/R5 rd", rd_n, !(s_on && !wr));
      chk(we_n == !(s_on && wr), "R4/R5 we", we_n, !(s_on && wr));
      chk(cs_n == ~c, "R6 cs", cs_n, ~c);
      chk(addr_out == ad, "R6/R9 addr", addr_out, ad);
      chk(oe == wr, "R8 oe", oe, wr);
      if (wr) chk(wdata_out == wd, "R8 wdata", wdata_out, wd);
      if (!wr && s_on && k == sd + 1) rdata_exp = pat ^ DW'(k);
    end
    @(negedge clk);
    start = 1'b0;
    check_idle("R2/R7 after access");
  endtask

  initial begin
    logic [7:0] n8, f0, f1, f2, f3;
    #20; @(negedge clk); check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk); check_idle("R1 after reset");
    chk(rdata == '0, "R1 rdata", rdata, 0);

    // example timing: count 11, enable 10/3, read 9/5
    run_access(0, 0, 19'h1234, 4'b0010, '0, 32'h05_09_03_0A, 32'h0000_070B, 32'hA5A5_0000, 0);
    // same on slow-port region, different count
    run_access(1, 0, 19'h0777, 4'b1000, '0, 32'h01_04_00_05, 32'h0000_060B, 32'h1111_2222, 1);
    // write access
    run_access(0, 1, 19'h7FFFF, 4'b0101, 32'hDEAD_BEEF, 32'h02_06_01_07, 32'h0000_0008, 32'h3333_4444, 1);
    // zero count: single clock, no strobes (R5)
    run_access(0, 0, 19'h0001, 4'b0001, '0, 32'h00_00_00_00, 32'h0000_0000, 32'h5555_6666, 0);
    // equal assert/release and assert beyond count (R5): rdata keeps value (R7)
    run_access(0, 0, 19'h0002, 4'b0011, '0, 32'h04_04_03_09, 32'h0000_0005, 32'h7777_8888, 0);
    // strobe released at 0 boundary
    run_access(1, 0, 19'h0003, 4'b1111, '0, 32'h00_03_00_03, 32'h0000_0300, 32'h9999_AAAA, 0);

    void'($urandom(32'd24681));
    for (int i = 0; i < 150; i++) begin
      n8 = 8'($urandom % 20);
      f0 = 8'($urandom % (int'(n8) + 3)); f1 = 8'($urandom % (int'(n8) + 3));
      f2 = 8'($urandom % (int'(n8) + 3)); f3 = 8'($urandom % (int'(n8) + 3));
      if (i % 2 == 0)
        run_access(1'($urandom), 1'($urandom), AW'($urandom), CSW'($urandom), $urandom,
                   {f3, f2, f1, f0}, {16'h0, n8, 8'($urandom % 20)}, $urandom, 1);
      else
        run_access(1'($urandom), 1'($urandom), AW'($urandom), CSW'($urandom), $urandom,
                   {f3, f2, f1, f0}, {16'h0, 8'($urandom % 20), n8}, $urandom, 1);
      if ($urandom % 3 == 0) @(negedge clk);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule